// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a fully received CAN frame is kept, and where it goes. It checks the frame identifier against six programmable filters. The filters form two groups. Filters 0 and 1 share mask 0 and feed receive buffer 0. Filters 2 to 5 share mask 1 and feed receive buffer 1. Each mask has a two-bit mode field. The mode decides how the frame type (standard or extended) is matched against the type bit of each filter.

The receive logic presents the identifier and the extended-frame flag together with a one-cycle `frame_vld` strobe. One clock later the block either pulses `acc_vld`, with the winning filter number and the target buffer, or stays silent. The filter and mask values are plain inputs, held steady by the register file that owns them.

Top module: `canf_accept_top`

## Requirements
- R1: Filters 0 and 1 steer a hit to buffer 0 (`acc_buf`=0). Filters 2 to 5 steer a hit to buffer 1 (`acc_buf`=1). Filter i takes its value from `filt_id[29*i +: 29]` and its type bit from `filt_ext[i]`. Group 0 uses `mask_id[28:0]` and `mask_mode[1:0]`. Group 1 uses `mask_id[57:29]` and `mask_mode[3:2]`.
- R2: A mask bit of 0 lets that identifier bit match whatever the filter bit is. A mask bit of 1 requires the frame bit and the filter bit to be equal.
- R3: A standard frame (`frame_ext`=0) is compared on identifier bits [28:18] only, so bits [17:0] have no effect. An extended frame (`frame_ext`=1) is compared on all 29 bits.
- R4: Mode 00 is the typed check. A filter can match only when its type bit equals `frame_ext`.
- R5: Mode 01 admits only standard frames into the group. Mode 10 admits only extended frames. In both modes the filters' type bits are ignored.
- R6: Mode 11 admits both frame types into the group, whatever the filters' type bits are.
- R7: When several filters match, the lowest-numbered one is reported. A group 0 hit therefore always beats a group 1 hit.
- R8: `acc_vld` pulses for exactly one cycle, one clock after a `frame_vld` cycle in which at least one filter matched. It stays low after a cycle without `frame_vld` and after a frame that no filter matched.
- R9: Synchronous reset drives `acc_vld`, `acc_buf` and `acc_idx` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe: a complete frame is presented |
| frame_id | input | 29 | Frame identifier; a standard identifier sits in [28:18] |
| frame_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| filt_id | input | 174 | Six 29-bit filter values, filter i at [29*i +: 29] |
| filt_ext | input | 6 | Per-filter type bit: 1 = extended |
| mask_id | input | 58 | Two 29-bit masks, group g at [29*g +: 29] |
| mask_mode | input | 4 | Two 2-bit mask modes, group g at [2*g +: 2] |
| acc_vld | output | 1 | Registered accept pulse |
| acc_buf | output | 1 | Target buffer of the accepted frame |
| acc_idx | output | 3 | Number of the winning filter |

## Verification
The bench builds the block with its default parameters: six filters, two of them in group 0, and 29-bit identifiers. It sweeps all 16 combinations of the two mask modes, two patterns of filter type bits and two mask settings. Against each setting it sends both frame types with identifiers that equal each filter, differ from it in one extended-only bit, or differ in one standard bit. This covers don't-care mask bits, identifiers matching several filters at once, and every mode against every type bit. Idle cycles, back-to-back frames and the reset state are checked separately.

// File: rtl/canf_pkg.sv
package canf_pkg;

    typedef enum logic [1:0] {
        MODE_TYPED    = 2'b00,
        MODE_STD_ONLY = 2'b01,
        MODE_EXT_ONLY = 2'b10,
        MODE_ANY      = 2'b11
    } mask_mode_e;

    // Frame-type gate of one filter under the mode of its group's mask.
    function automatic logic type_pass(input mask_mode_e mode,
                                       input logic frm_ext,
                                       input logic flt_ext);
        logic ok;
        case (mode)
            MODE_TYPED:    ok = (frm_ext == flt_ext);
            MODE_STD_ONLY: ok = ~frm_ext;
            MODE_EXT_ONLY: ok = frm_ext;
            default:       ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/canf_match_unit.sv
module canf_match_unit
    import canf_pkg::*;
#(
    parameter int ID_W  = 29,
    parameter int STD_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] frm_id,
    input  logic            frm_ext,
    input  logic [ID_W-1:0] flt_id,
    input  logic            flt_ext,
    input  logic [ID_W-1:0] msk_id,
    input  mask_mode_e      msk_mode,
    output logic            hit
);
    localparam int LOW_W = ID_W - STD_W;
    localparam logic [ID_W-1:0] STD_SEL = {{STD_W{1'b1}}, {LOW_W{1'b0}}};

    logic [ID_W-1:0] cmp_sel;
    logic            bits_ok;
    logic            kind_ok;

    always_comb begin
        cmp_sel = frm_ext ? {ID_W{1'b1}} : STD_SEL;
        bits_ok = (((frm_id ^ flt_id) & msk_id & cmp_sel) == '0);
        kind_ok = type_pass(msk_mode, frm_ext, flt_ext);
        hit     = bits_ok & kind_ok;
    end

    // R5
    std_only_chk: assert property (@(posedge clk) disable iff (rst)
        (msk_mode == MODE_STD_ONLY && frm_ext) |-> !hit);

    // R5
    ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        (msk_mode == MODE_EXT_ONLY && !frm_ext) |-> !hit);

endmodule

// File: rtl/canf_prio_pick.sv
module canf_prio_pick #(
    parameter int N    = 6,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    hits,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

    // R7
    pick_is_hit_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> hits[idx]);

    // R7
    pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ((hits & ((N'(1) << idx) - N'(1))) == '0));

endmodule

// File: rtl/canf_accept_top.sv
module canf_accept_top
    import canf_pkg::*;
#(
    parameter int ID_W     = 29,
    parameter int STD_W    = 11,
    parameter int NUM_FILT = 6,
    parameter int GRP0_CNT = 2,
    localparam int IDX_W   = $clog2(NUM_FILT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_vld,
    input  logic [ID_W-1:0]          frame_id,
    input  logic                     frame_ext,
    input  logic [NUM_FILT*ID_W-1:0] filt_id,
    input  logic [NUM_FILT-1:0]      filt_ext,
    input  logic [2*ID_W-1:0]        mask_id,
    input  logic [3:0]               mask_mode,
    output logic                     acc_vld,
    output logic                     acc_buf,
    output logic [IDX_W-1:0]         acc_idx
);
    logic [NUM_FILT-1:0] hit_vec;
    logic                pick_any;
    logic [IDX_W-1:0]    pick_idx;

    for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
        localparam int GRP = (i < GRP0_CNT) ? 0 : 1;
        canf_match_unit #(
            .ID_W  (ID_W),
            .STD_W (STD_W)
        ) u_match (
            .clk      (clk),
            .rst      (rst),
            .frm_id   (frame_id),
            .frm_ext  (frame_ext),
            .flt_id   (filt_id[i*ID_W +: ID_W]),
            .flt_ext  (filt_ext[i]),
            .msk_id   (mask_id[GRP*ID_W +: ID_W]),
            .msk_mode (mask_mode_e'(mask_mode[GRP*2 +: 2])),
            .hit      (hit_vec[i])
        );
    end

    canf_prio_pick #(
        .N    (NUM_FILT),
        .IDXW (IDX_W)
    ) u_pick (
        .clk  (clk),
        .rst  (rst),
        .hits (hit_vec),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_vld <= 1'b0;
            acc_buf <= 1'b0;
            acc_idx <= '0;
        end else begin
            acc_vld <= frame_vld & pick_any;
            if (frame_vld & pick_any) begin
                acc_idx <= pick_idx;
                acc_buf <= ({1'b0, pick_idx} >= (IDX_W+1)'(GRP0_CNT));
            end
        end
    end

    // R8
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |-> $past(frame_vld));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |-> ({1'b0, acc_idx} < (IDX_W+1)'(NUM_FILT)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!acc_vld && !acc_buf && acc_idx == '0));

endmodule

// File: tb/canf_accept_top_test.sv
module canf_accept_top_test;
    localparam int IW = 29;
    localparam int NF = 6;

    logic            clk = 1'b0;
    logic            rst;
    logic            frame_vld;
    logic [IW-1:0]   frame_id;
    logic            frame_ext;
    logic [NF*IW-1:0] filt_id;
    logic [NF-1:0]   filt_ext;
    logic [2*IW-1:0] mask_id;
    logic [3:0]      mask_mode;
    logic            acc_vld;
    logic            acc_buf;
    logic [2:0]      acc_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    canf_accept_top uut (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_id(frame_id),
        .frame_ext(frame_ext), .filt_id(filt_id), .filt_ext(filt_ext),
        .mask_id(mask_id), .mask_mode(mask_mode),
        .acc_vld(acc_vld), .acc_buf(acc_buf), .acc_idx(acc_idx)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual {vld,buf,idx}=%b expected %b", tag, act, exp);
        end
    endtask

    // Arithmetic model of R1 to R7: returns {vld, buf, idx}.
    function automatic logic [4:0] model(input logic [IW-1:0] id, input logic ext);
        for (int i = 0; i < NF; i++) begin
            int g = (i < 2) ? 0 : 1;
            logic [1:0] md = mask_mode[2*g +: 2];
            logic [IW-1:0] mv = mask_id[g*IW +: IW];
            logic [IW-1:0] fv = filt_id[i*IW +: IW];
            logic [IW-1:0] cm = ext ? {IW{1'b1}} : {{11{1'b1}}, 18'h0};
            logic tok;
            case (md)
                2'b00:   tok = (filt_ext[i] == ext);
                2'b01:   tok = !ext;
                2'b10:   tok = ext;
                default: tok = 1'b1;
            endcase
            if (tok && (((id ^ fv) & mv & cm) == '0))
                return {1'b1, (i >= 2), 3'(i)};
        end
        return 5'b0;
    endfunction

    task automatic send(input logic [IW-1:0] id, input logic ext, input string tag);
        logic [4:0] exp;
        @(negedge clk);
        frame_id = id; frame_ext = ext; frame_vld = 1'b1;
        exp = model(id, ext);
        @(negedge clk);
        frame_vld = 1'b0;
        if (exp[4])
            check(tag, {acc_vld, acc_buf, acc_idx}, exp);
        else
            check(tag, {acc_vld, 4'b0}, 5'b0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_vld = 1'b0; frame_id = '0; frame_ext = 1'b0;
        filt_ext = '0; mask_id = '1; mask_mode = '0;
        for (int i = 0; i < NF; i++)
            filt_id[i*IW +: IW] = {11'(i*3 + 1), 18'(i*7 + 5)};
        // Filter 4 shares filter 1's standard bits so standard frames hit both.
        filt_id[4*IW +: IW] = {11'(4), 18'h2A};
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", {acc_vld, acc_buf, acc_idx}, 5'b0);
        rst = 1'b0;

        // R8: idle cycles give no pulse
        repeat (3) @(negedge clk);
        check("R8 idle", {acc_vld, acc_buf, acc_idx}, 5'b0);

        // Sweep: R1,R2,R3,R4,R5,R6,R7
        for (int fe = 0; fe < 2; fe++) begin
            filt_ext = (fe == 0) ? 6'b101010 : 6'b010110;
            for (int mc = 0; mc < 2; mc++) begin
                if (mc == 0) mask_id = '1;
                else mask_id = {29'h1FF3FFFE, 29'h1FFBFFFE};
                for (int md = 0; md < 16; md++) begin
                    mask_mode = 4'(md);
                    for (int ex = 0; ex < 2; ex++) begin
                        for (int j = 0; j < NF; j++) begin
                            logic [IW-1:0] f = filt_id[j*IW +: IW];
                            send(f, ex[0], "R1,R2,R3,R4,R5,R6,R7 equal");
                            send(f ^ 29'h1, ex[0], "R2,R3 low bit");
                            send(f ^ 29'h40000, ex[0], "R2,R3 std bit");
                        end
                    end
                end
            end
        end

        // R8: pulse lasts one cycle and back-to-back frames each pulse
        mask_mode = 4'b1111; mask_id = '1;
        @(negedge clk);
        frame_id = filt_id[0 +: IW]; frame_ext = 1'b0; frame_vld = 1'b1;
        @(negedge clk);
        frame_id = filt_id[3*IW +: IW]; frame_ext = 1'b1;
        check("R8 first of pair", {acc_vld, acc_buf, acc_idx}, 5'b10000);
        @(negedge clk);
        frame_vld = 1'b0;
        check("R8 second of pair", {acc_vld, acc_buf, acc_idx}, 5'b11011);
        @(negedge clk);
        check("R8 pulse ends", {acc_vld, 4'b0}, 5'b0);

        // R9: reset in the middle of a pulse
        frame_id = filt_id[0 +: IW]; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R9 reset clears", {acc_vld, acc_buf, acc_idx}, 5'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule